// File: doc/BRIEF.md
# Two-Thread Register Alias Table with Reorder-Buffer Tags

This block sits at the rename stage of a small out-of-order core that runs two hardware threads. For each thread it keeps one entry per architected register. An entry either says the current value is already in the architected register file, or it names the reorder-buffer slot of the newest in-flight instruction that will produce that register. Each rename port presents a thread number, two source register numbers and an optional destination. The port gets back, in the same cycle, where each source comes from. When the instruction writes a destination, the slot tag it was given is recorded for that register.

Ports are ordered, lowest index oldest. A source is looked up against the table as it stood before the cycle began. A younger port in the same cycle and the same thread also sees the destination names that older ports give out. A commit port returns an entry to the "in architected file" state, but only while that entry still names the committing slot. Tag allocation, register values and mispredict recovery are handled elsewhere.

Top module: `rob_rename_map`

## Requirements
- R1: After reset every entry of both threads reads as not busy (busy output 0), meaning the value is in the architected file.
- R2: A port with rn_valid=1 and rn_dst_en=1 records its rn_tag for (rn_tid, rn_dst). From the next cycle, a lookup of that register returns busy=1 with that tag.
- R3: A recorded mapping stays in place until a later rename of the same register in the same thread, which replaces it with the newer tag.
- R4: The two threads have separate tables. A rename in one thread does not change the lookup result for the same register number in the other thread.
- R5: When an instruction reads the register it also writes, its source lookup returns the mapping that existed before its own destination update.
- R6: In one cycle, a source on a higher-numbered port of the same thread that matches a lower port's destination returns busy=1 with the lower port's tag. If several lower ports match, the highest-numbered of them is used.
- R7: When two ports in one cycle rename the same register of the same thread, the higher-numbered port's tag is the one left in the table.
- R8: A commit (cm_valid=1) whose cm_tag equals the busy entry at (cm_tid, cm_areg) makes that entry read not busy from the next cycle.
- R9: A commit whose tag differs from the entry's stored tag, or whose entry is not busy, leaves the table unchanged.
- R10: A rename and a commit to the same entry in the same cycle leave the rename's tag in the table.
- R11: A port with rn_valid=0, or with rn_dst_en=0, does not change the table.
- R12: Same-cycle forwarding between ports applies only when the ports carry the same thread number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rn_valid | input | RN_PORTS | Per-port instruction present |
| rn_tid | input | RN_PORTS x TID_W | Per-port thread number |
| rn_src_a | input | RN_PORTS x AREG_W | Per-port first source register |
| rn_src_b | input | RN_PORTS x AREG_W | Per-port second source register |
| rn_dst_en | input | RN_PORTS | Per-port instruction writes a destination |
| rn_dst | input | RN_PORTS x AREG_W | Per-port destination register |
| rn_tag | input | RN_PORTS x TAG_W | Per-port reorder-buffer slot given to the instruction |
| rn_a_busy | output | RN_PORTS | First source is waiting on an in-flight producer |
| rn_a_tag | output | RN_PORTS x TAG_W | Producer slot for the first source |
| rn_b_busy | output | RN_PORTS | Second source is waiting on an in-flight producer |
| rn_b_tag | output | RN_PORTS x TAG_W | Producer slot for the second source |
| cm_valid | input | 1 | A slot is committing |
| cm_tid | input | TID_W | Thread of the committing slot |
| cm_areg | input | AREG_W | Destination register of the committing slot |
| cm_tag | input | TAG_W | Slot number that is committing |

## Verification
The hardest case to reach from the ports is a commit that arrives after its register has already been renamed again. The bench sets it up by renaming one register twice, then committing the older tag, and checks that the newer mapping survives. It also lines up a rename and a matching commit on the same edge, and sends same-cycle port pairs that share or differ in thread, destination and source. Together these cover the forwarding and priority rules.

// File: rtl/rob_rename_map.sv
module rob_rename_map #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_AREGS   = 16,
  parameter int ROB_DEPTH   = 8,
  parameter int RN_PORTS    = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [RN_PORTS-1:0]                    rn_valid,
  input  logic [RN_PORTS-1:0][((NUM_THREADS>1)?$clog2(NUM_THREADS):1)-1:0] rn_tid,
  input  logic [RN_PORTS-1:0][$clog2(NUM_AREGS)-1:0] rn_src_a,
  input  logic [RN_PORTS-1:0][$clog2(NUM_AREGS)-1:0] rn_src_b,
  input  logic [RN_PORTS-1:0]                    rn_dst_en,
  input  logic [RN_PORTS-1:0][$clog2(NUM_AREGS)-1:0] rn_dst,
  input  logic [RN_PORTS-1:0][$clog2(ROB_DEPTH)-1:0] rn_tag,
  output logic [RN_PORTS-1:0]                    rn_a_busy,
  output logic [RN_PORTS-1:0][$clog2(ROB_DEPTH)-1:0] rn_a_tag,
  output logic [RN_PORTS-1:0]                    rn_b_busy,
  output logic [RN_PORTS-1:0][$clog2(ROB_DEPTH)-1:0] rn_b_tag,
  input  logic                                   cm_valid,
  input  logic [((NUM_THREADS>1)?$clog2(NUM_THREADS):1)-1:0] cm_tid,
  input  logic [$clog2(NUM_AREGS)-1:0]           cm_areg,
  input  logic [$clog2(ROB_DEPTH)-1:0]           cm_tag
);
  localparam int TAG_W = $clog2(ROB_DEPTH);
  localparam int ENT_W = TAG_W + 1;

  // entry = {busy, tag}
  logic [NUM_THREADS-1:0][NUM_AREGS-1:0][ENT_W-1:0] map_q;
  logic [RN_PORTS-1:0][ENT_W-1:0] ent_a, ent_b;

  logic [RN_PORTS-1:0] wr_en;
  assign wr_en = rn_valid & rn_dst_en;

  always_comb begin
    for (int p = 0; p < RN_PORTS; p++) begin
      ent_a[p] = map_q[rn_tid[p]][rn_src_a[p]];
      ent_b[p] = map_q[rn_tid[p]][rn_src_b[p]];
      for (int q = 0; q < RN_PORTS; q++) begin
        if (q < p && wr_en[q] && rn_tid[q] == rn_tid[p]) begin
          if (rn_dst[q] == rn_src_a[p]) ent_a[p] = {1'b1, rn_tag[q]};
          if (rn_dst[q] == rn_src_b[p]) ent_b[p] = {1'b1, rn_tag[q]};
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < RN_PORTS; g++) begin : g_out
      assign rn_a_busy[g] = ent_a[g][TAG_W];
      assign rn_a_tag[g]  = ent_a[g][TAG_W-1:0];
      assign rn_b_busy[g] = ent_b[g][TAG_W];
      assign rn_b_tag[g]  = ent_b[g][TAG_W-1:0];
    end
  endgenerate

  logic cm_hit;
  assign cm_hit = cm_valid && (map_q[cm_tid][cm_areg] == {1'b1, cm_tag});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q <= '0;
    end else begin
      if (cm_hit) map_q[cm_tid][cm_areg] <= '0;
      for (int p = 0; p < RN_PORTS; p++)
        if (wr_en[p]) map_q[rn_tid[p]][rn_dst[p]] <= {1'b1, rn_tag[p]};
    end
  end
endmodule

// File: rtl/rob_rename_map_chk.sv
module rob_rename_map_chk #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_AREGS   = 16,
  parameter int ROB_DEPTH   = 8,
  parameter int RN_PORTS    = 2
) (
  input logic clk,
  input logic rst_n,
  input logic [RN_PORTS-1:0] rn_valid,
  input logic [RN_PORTS-1:0][((NUM_THREADS>1)?$clog2(NUM_THREADS):1)-1:0] rn_tid,
  input logic [RN_PORTS-1:0] rn_dst_en,
  input logic [RN_PORTS-1:0][$clog2(NUM_AREGS)-1:0] rn_dst,
  input logic [RN_PORTS-1:0][$clog2(ROB_DEPTH)-1:0] rn_tag,
  input logic cm_valid,
  input logic [((NUM_THREADS>1)?$clog2(NUM_THREADS):1)-1:0] cm_tid,
  input logic [$clog2(NUM_AREGS)-1:0] cm_areg,
  input logic [$clog2(ROB_DEPTH)-1:0] cm_tag,
  input logic [NUM_THREADS-1:0][NUM_AREGS-1:0][$clog2(ROB_DEPTH):0] map_q
);
  localparam int L = RN_PORTS - 1;

  // R1
  r1_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> map_q == '0);

  // R2
  r2_last_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rn_valid[L] && rn_dst_en[L] |=>
      map_q[$past(rn_tid[L])][$past(rn_dst[L])] == {1'b1, $past(rn_tag[L])});

  // R8
  r8_commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && rn_valid == '0 && map_q[cm_tid][cm_areg] == {1'b1, cm_tag} |=>
      map_q[$past(cm_tid)][$past(cm_areg)] == '0);

  // R9
  r9_stale_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && rn_valid == '0 && map_q[cm_tid][cm_areg] != {1'b1, cm_tag} |=>
      $stable(map_q));

  // R11
  r11_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rn_valid & rn_dst_en) == '0 && !cm_valid |=> $stable(map_q));
endmodule

bind rob_rename_map rob_rename_map_chk #(
  .NUM_THREADS(NUM_THREADS), .NUM_AREGS(NUM_AREGS),
  .ROB_DEPTH(ROB_DEPTH), .RN_PORTS(RN_PORTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_tid(rn_tid),
  .rn_dst_en(rn_dst_en), .rn_dst(rn_dst), .rn_tag(rn_tag),
  .cm_valid(cm_valid), .cm_tid(cm_tid), .cm_areg(cm_areg), .cm_tag(cm_tag),
  .map_q(map_q)
);

// File: tb/rob_rename_map_test.sv
module rob_rename_map_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 2;

  logic clk = 0, rst_n = 0;
  logic [P-1:0] rn_valid, rn_dst_en, rn_a_busy, rn_b_busy;
  logic [P-1:0][0:0] rn_tid;
  logic [P-1:0][3:0] rn_src_a, rn_src_b, rn_dst;
  logic [P-1:0][2:0] rn_tag, rn_a_tag, rn_b_tag;
  logic cm_valid;
  logic [0:0] cm_tid;
  logic [3:0] cm_areg;
  logic [2:0] cm_tag;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rob_rename_map uut (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_tid(rn_tid),
    .rn_src_a(rn_src_a), .rn_src_b(rn_src_b), .rn_dst_en(rn_dst_en),
    .rn_dst(rn_dst), .rn_tag(rn_tag), .rn_a_busy(rn_a_busy), .rn_a_tag(rn_a_tag),
    .rn_b_busy(rn_b_busy), .rn_b_tag(rn_b_tag), .cm_valid(cm_valid),
    .cm_tid(cm_tid), .cm_areg(cm_areg), .cm_tag(cm_tag)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual {busy,tag}=%b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    rn_valid = '0; rn_dst_en = '0; rn_tid = '0; rn_src_a = '0;
    rn_src_b = '0; rn_dst = '0; rn_tag = '0;
    cm_valid = 0; cm_tid = '0; cm_areg = '0; cm_tag = '0;
  endtask

  task automatic setp(int p, bit v, bit t, int a, int b, bit de, int d, int tg);
    rn_valid[p] = v; rn_tid[p] = t; rn_src_a[p] = 4'(a); rn_src_b[p] = 4'(b);
    rn_dst_en[p] = de; rn_dst[p] = 4'(d); rn_tag[p] = 3'(tg);
  endtask

  task automatic look(string req, bit t, int r, bit busy, int tg);
    @(negedge clk); idle();
    setp(0, 0, t, r, r, 0, 0, 0);
    #1;
    chk(req, {rn_a_busy[0], rn_a_tag[0]}, busy ? {1'b1, 3'(tg)} : 4'b0);
  endtask

  task automatic ren(bit t, int d, int tg);
    @(negedge clk); idle();
    setp(0, 1, t, 0, 0, 1, d, tg);
  endtask

  task automatic t_reset();
    for (int t = 0; t < 2; t++)
      for (int r = 0; r < 16; r++) look("R1", t[0], r, 0, 0);
  endtask

  task automatic t_basic();
    ren(0, 3, 5);
    look("R2", 0, 3, 1, 5);
    look("R2", 0, 4, 0, 0);
    ren(0, 3, 6);
    look("R3", 0, 3, 1, 6);
  endtask

  task automatic t_threads();
    ren(1, 12, 2);
    look("R4", 0, 12, 0, 0);
    look("R4", 1, 12, 1, 2);
    @(negedge clk); idle();
    setp(0, 1, 0, 0, 0, 1, 7, 1);
    setp(1, 1, 1, 7, 7, 0, 0, 0);
    #1;
    chk("R12", {rn_a_busy[1], rn_a_tag[1]}, 4'b0);
  endtask

  task automatic t_self();
    @(negedge clk); idle();
    setp(0, 1, 0, 3, 3, 1, 3, 7);
    #1;
    chk("R5", {rn_a_busy[0], rn_a_tag[0]}, 4'b1110);
    look("R5", 0, 3, 1, 7);
  endtask

  task automatic t_bypass();
    @(negedge clk); idle();
    setp(0, 1, 0, 0, 0, 1, 9, 3);
    setp(1, 1, 0, 9, 10, 0, 0, 0);
    #1;
    chk("R6", {rn_a_busy[1], rn_a_tag[1]}, 4'b1011);
    chk("R6", {rn_b_busy[1], rn_b_tag[1]}, 4'b0);
    @(negedge clk); idle();
    setp(0, 1, 0, 0, 0, 1, 10, 4);
    setp(1, 1, 0, 0, 0, 1, 10, 1);
    look("R7", 0, 10, 1, 1);
  endtask

  task automatic t_commit();
    @(negedge clk); idle();
    cm_valid = 1; cm_tid = 0; cm_areg = 9; cm_tag = 2;
    look("R9", 0, 9, 1, 3);
    @(negedge clk); idle();
    cm_valid = 1; cm_tid = 0; cm_areg = 5; cm_tag = 0;
    look("R9", 0, 5, 0, 0);
    ren(0, 6, 2);
    ren(0, 6, 4);
    @(negedge clk); idle();
    cm_valid = 1; cm_tid = 0; cm_areg = 6; cm_tag = 2;
    look("R9", 0, 6, 1, 4);
    @(negedge clk); idle();
    cm_valid = 1; cm_tid = 1; cm_areg = 12; cm_tag = 2;
    look("R8", 1, 12, 0, 0);
    look("R8", 0, 9, 1, 3);
  endtask

  task automatic t_race();
    @(negedge clk); idle();
    setp(0, 1, 0, 0, 0, 1, 10, 5);
    cm_valid = 1; cm_tid = 0; cm_areg = 10; cm_tag = 1;
    look("R10", 0, 10, 1, 5);
  endtask

  task automatic t_gate();
    @(negedge clk); idle();
    setp(0, 1, 0, 0, 0, 0, 11, 2);
    look("R11", 0, 11, 0, 0);
    @(negedge clk); idle();
    setp(1, 0, 0, 0, 0, 1, 11, 2);
    look("R11", 0, 11, 0, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_basic();
    t_threads();
    t_self();
    t_bypass();
    t_commit();
    t_race();
    t_gate();
    finish_run();
  end
endmodule